// File: doc/BRIEF.md
# Duty-Cycle-Encoded Serial Bit Transmitter

This block turns a stream of bytes into a single-wire pulse train in which every bit occupies one fixed-length period. The line rises at the start of each period. How long it stays high tells the far end the bit value: a long high phase means one and a shorter high phase means zero. By default the period is 25 clock ticks. A one is high for 20 ticks (80 %) and a zero is high for 13 ticks (52 %). The period and both high times are parameters.

Bytes arrive on a ready/valid port, such as the read side of a FIFO. Each accepted byte is sent as eight periods, most significant bit first. The block waits without limit for data and pulses only while it has a byte to send. When the next byte is already valid as the last period of the current byte ends, that byte follows with no idle gap. Only one tick counter and one shift register are used. The high time of each period is chosen at run time from the bit being sent, so no delay table is built per bit position.

Top module: `duty_bit_tx`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) discards any partly sent byte and leaves the block idle: line_o low, busy_o low, in_ready high.
- R2: A bit of value one drives line_o high for HIGH_ONE consecutive cycles (default 20), then low for the rest of its PERIOD-cycle period (default 25).
- R3: A bit of value zero drives line_o high for HIGH_ZERO consecutive cycles (default 13), then low for the rest of its PERIOD-cycle period.
- R4: Each accepted byte is sent as exactly WORD_W (8) consecutive periods, bit WORD_W-1 first and bit 0 last. No byte is lost or repeated.
- R5: A byte is accepted at a clock edge where in_valid and in_ready are both high. Its first period starts at that edge, so line_o and busy_o are high in the following cycle. Every period starts with line_o high and ends with it low.
- R6: in_ready is high while the block is idle, and in the final cycle of the final period of a byte. It is low in every other cycle.
- R7: When in_valid is high during the final cycle of a byte, the next byte starts at once. busy_o stays high without a gap, so n bytes sent back to back give one busy run of n*WORD_W*PERIOD cycles.
- R8: With no byte available, line_o stays low and busy_o stays low for as long as in_valid stays low.
- R9: busy_o is high from the cycle after acceptance through the last cycle of the byte's final period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | WORD_W | Byte to send |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Block takes in_data at this edge if in_valid is high |
| line_o | output | 1 | Encoded serial line |
| busy_o | output | 1 | A byte is being sent |

## Verification
The hardest situation to reach is the byte-to-byte handover. The next byte must be taken in exactly the final tick of the final bit, with no gap and no lost or repeated byte. The stimulus reaches it by holding in_valid high with the following byte while the current byte is still sending. It then checks that the busy run covers every period of the chain. A reset asserted partway through a byte is also driven, to confirm that the rest of that byte never appears on the line.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;
endpackage

// File: rtl/dbt_tick_timer.sv
module dbt_tick_timer #(
    parameter int PERIOD = 25,
    parameter int CNT_W  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    output logic [CNT_W-1:0] cnt_o,
    output logic             end_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (clear) begin
            t_d.cnt = '0;
        end else if (run) begin
            t_d.cnt = (t_q.cnt == LAST) ? '0 : t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign cnt_o = t_q.cnt;
    assign end_o = (t_q.cnt == LAST);
endmodule

// File: rtl/dbt_bit_reg.sv
module dbt_bit_reg #(
    parameter int WORD_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] data,
    input  logic              shift,
    output logic              msb_o,
    output logic              last_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [IDX_W-1:0]  idx;
    } breg_t;

    breg_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (load) begin
            b_d.sh  = data;
            b_d.idx = '0;
        end else if (shift) begin
            b_d.sh  = {b_q.sh[WORD_W-2:0], 1'b0};
            b_d.idx = b_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign msb_o  = b_q.sh[WORD_W-1];
    assign last_o = (b_q.idx == LAST_IDX);
endmodule

// File: rtl/duty_bit_tx.sv
module duty_bit_tx
    import dbt_pkg::*;
#(
    parameter int PERIOD    = 25,
    parameter int HIGH_ONE  = 20,
    parameter int HIGH_ZERO = 13,
    parameter int WORD_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              line_o,
    output logic              busy_o
);
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam int IDX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W:0] ONE_LEN  = (CNT_W + 1)'(HIGH_ONE);
    localparam logic [CNT_W:0] ZERO_LEN = (CNT_W + 1)'(HIGH_ZERO);

    typedef struct packed {
        tx_state_e st;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [CNT_W-1:0] tick_cnt;
    logic             tick_end;
    logic             cur_bit;
    logic             last_bit;
    logic             accept;
    logic             shift_en;
    logic             sending;
    logic [CNT_W:0]   high_len;

    always_comb begin
        c_d      = c_q;
        sending  = (c_q.st == ST_SEND);
        in_ready = !sending || (tick_end && last_bit);
        accept   = in_valid && in_ready;
        shift_en = sending && tick_end && !last_bit;
        if (accept) begin
            c_d.st = ST_SEND;
        end else if (sending && tick_end && last_bit) begin
            c_d.st = ST_IDLE;
        end
        high_len = cur_bit ? ONE_LEN : ZERO_LEN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    dbt_tick_timer #(
        .PERIOD (PERIOD),
        .CNT_W  (CNT_W)
    ) timer_i (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .run   (sending),
        .cnt_o (tick_cnt),
        .end_o (tick_end)
    );

    dbt_bit_reg #(
        .WORD_W (WORD_W),
        .IDX_W  (IDX_W)
    ) bits_i (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .data   (in_data),
        .shift  (shift_en),
        .msb_o  (cur_bit),
        .last_o (last_bit)
    );

    assign line_o = sending && ({1'b0, tick_cnt} < high_len);
    assign busy_o = sending;
endmodule

// File: rtl/dbt_checker.sv
module dbt_checker #(
    parameter int HIGH_ONE  = 20,
    parameter int HIGH_ZERO = 13
) (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic line_o,
    input logic busy_o
);
    logic [15:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
        end else begin
            hi_run <= line_o ? hi_run + 16'd1 : 16'd0;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!busy_o && !line_o && in_ready)); // R1

    AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (rst)
        ($fell(line_o) && !$past(rst)) |-> (hi_run == 16'(HIGH_ONE) || hi_run == 16'(HIGH_ZERO))); // R2

    AST_HIGH_MIN: assert property (@(posedge clk) disable iff (rst)
        ($fell(line_o) && !$past(rst)) |-> (hi_run >= 16'(HIGH_ZERO))); // R3

    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (busy_o && line_o)); // R5

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> in_ready); // R6

    AST_CHAIN: assert property (@(posedge clk) disable iff (rst)
        (busy_o && in_ready && in_valid) |=> busy_o); // R7

    AST_DROP_IDLE: assert property (@(posedge clk) disable iff (rst)
        (busy_o && in_ready && !in_valid) |=> (!busy_o && !line_o)); // R8

    AST_HOLD_MIDWORD: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !in_ready) |=> busy_o); // R9
endmodule

bind duty_bit_tx dbt_checker #(
    .HIGH_ONE  (HIGH_ONE),
    .HIGH_ZERO (HIGH_ZERO)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .line_o   (line_o),
    .busy_o   (busy_o)
);

// File: tb/duty_bit_tx_tb_top.sv
`timescale 1ns/1ps
module duty_bit_tx_tb_top;
    localparam int P  = 25;
    localparam int H1 = 20;
    localparam int H0 = 13;
    localparam int W  = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] in_data = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         line_o;
    logic         busy_o;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;
    bit          done   = 1'b0;
    bit          exp_q[$];

    int pos = 0, bidx = 0, hi = 0, run = 0, last_run = 0;
    bit seen_low = 1'b0;

    always #2.5 clk = ~clk;

    duty_bit_tx #(.PERIOD(P), .HIGH_ONE(H1), .HIGH_ZERO(H0), .WORD_W(W)) dut_i (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .line_o(line_o), .busy_o(busy_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: decodes every period and checks it against the scoreboard queue.
    always @(negedge clk) begin
        if (rst) begin
            pos = 0; bidx = 0; hi = 0; run = 0; seen_low = 1'b0;
        end else if (!busy_o) begin
            check(line_o == 1'b0, "R8 idle line", int'(line_o), 0);
            check(in_ready == 1'b1, "R6 ready idle", int'(in_ready), 1);
            if (run > 0) last_run = run;
            run = 0; pos = 0; bidx = 0; hi = 0; seen_low = 1'b0;
        end else begin
            run++;
            check(in_ready == ((pos == P-1) && (bidx == W-1)), "R6 ready timing",
                  int'(in_ready), int'((pos == P-1) && (bidx == W-1)));
            if (pos == 0) check(line_o == 1'b1, "R5 period starts high", int'(line_o), 1);
            if (line_o) begin
                if (seen_low) check(1'b0, "R5 rise inside period", pos, -1);
                hi++;
            end else begin
                seen_low = 1'b1;
            end
            if (pos == P-1) begin
                check(line_o == 1'b0, "R5 period ends low", int'(line_o), 0);
                check(hi == H1 || hi == H0, "R2/R3 high width", hi, H1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected period", hi, 0);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    check(hi == (e ? H1 : H0), e ? "R2 one bit width" : "R3 zero bit width",
                          hi, e ? H1 : H0);
                end
                hi = 0; seen_low = 1'b0; pos = 0;
                bidx = (bidx == W-1) ? 0 : bidx + 1;
            end else begin
                pos++;
            end
        end
    end

    // Driver: offers a byte, pushes its bits MSB first once it is taken.
    task automatic send_byte(input logic [W-1:0] b);
        @(negedge clk);
        in_data  = b;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        for (int i = W-1; i >= 0; i--) exp_q.push_back(b[i]);
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!line_o && !busy_o && in_ready, "R1 reset state", int'({line_o, busy_o, in_ready}), 1);
        rst = 1'b0;

        send_byte(8'hA5);
        go_idle();
        wait_idle();
        check(exp_q.size() == 0, "R4 A5 fully sent", exp_q.size(), 0);
        check(last_run == W*P, "R9 single byte busy run", last_run, W*P);

        send_byte(8'hFF);
        send_byte(8'h00);
        go_idle();
        wait_idle();
        check(last_run == 2*W*P, "R7 back-to-back two bytes", last_run, 2*W*P);

        send_byte(8'h80);
        send_byte(8'h01);
        send_byte(8'h3C);
        go_idle();
        wait_idle();
        check(last_run == 3*W*P, "R7 back-to-back three bytes", last_run, 3*W*P);
        check(exp_q.size() == 0, "R4 chain fully sent", exp_q.size(), 0);

        repeat (60) @(negedge clk);
        check(!busy_o && !line_o, "R8 long idle", int'({busy_o, line_o}), 0);

        send_byte(8'h5A);
        go_idle();
        repeat (100) @(negedge clk);
        rst = 1'b1;
        exp_q.delete();
        repeat (3) @(negedge clk);
        check(!line_o && !busy_o && in_ready, "R1 reset mid-byte", int'({line_o, busy_o, in_ready}), 1);
        rst = 1'b0;
        repeat (2 * W * P) @(negedge clk);
        check(!busy_o && !line_o, "R1 discarded byte stays gone", int'({busy_o, line_o}), 0);

        send_byte(8'hC3);
        @(negedge clk);
        in_valid = 1'b0;
        check(busy_o && line_o, "R5 starts after accept", int'({busy_o, line_o}), 3);
        wait_idle();
        check(exp_q.size() == 0, "R4 C3 fully sent", exp_q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule